// File: doc/BRIEF.md
# SM3 Hash-Assist Execution Unit

This unit evaluates a single SM3 hash-assist vector operation per accepted request. Each operand is a 128-bit value that the unit splits into four 32-bit words, with word 0 in bits 31:0 and word 3 in bits 127:96. There are seven operations. Two of them expand message words. One computes the SS1 rotate-and-add term. The remaining four are compression-round variants. The round variants shift the state words of D down by one word and place a freshly computed word at the top.

A request is presented with `in_valid` high for one cycle, together with the destination/state operand D, the sources N, M and A, an operation select, a 2-bit word index and a feature-enable bit. The result appears one clock later, registered, with `out_valid` high. A request is flagged undefined if the feature-enable bit is clear or if the operation code is reserved. An undefined request returns D unchanged. Full block iteration and round-constant generation are left to the surrounding logic.

Top module: `sm3_assist_unit`

## Requirements
- R1: While reset is asserted and after its release, `out_valid`, `undef` and `d_out` are all zero until the first request is accepted.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `d_out` and `undef` change only in that cycle and hold their values between requests.
- R3: Expansion part 1 is `op_sel`=4. For words i = 0..2, t = D[i] ^ N[i] ^ ror(M[i+1],17). For word 3, t = D[3] ^ N[3] ^ ror(new word 0,17). Each result word is t ^ ror(t,17) ^ ror(t,9).
- R4: Expansion part 2 is `op_sel`=5. Every result word is D[i] ^ N[i] ^ ror(M[i],25). Word 3 also XORs ror(u,17) ^ ror(u,2) ^ ror(u,26), where u = N[0] ^ ror(M[0],25).
- R5: SS1 is `op_sel`=6. Result words 0..2 are zero. Word 3 is ror(ror(N[3],20) + M[3] + A[3], 25), with the additions taken modulo 2^32.
- R6: The compression variants are `op_sel` 0..3. Each computes t = f(D3,D2,D1) + D0 + M[imm2] modulo 2^32. The result is then: word 0 = old D1, word 2 = old D3, word 3 = final t.
- R7: The function f is selected by `op_sel`. It is XOR parity for 0 and 2, bitwise majority for 1, and choose (D3 ? D2 : D1, bitwise) for 3. The input `imm2` selects which word of M is added.
- R8: For `op_sel` 0 and 1, t gains N[3] ^ ror(old D3,20), and word 1 becomes ror(old D2,23).
- R9: For `op_sel` 2 and 3, t gains N[3] and is then replaced by t ^ rol(t,9) ^ rol(t,17). Word 1 becomes ror(old D2,13).
- R10: When `feat_en` is low on an accepted request, `undef` is set and `d_out` equals the D of that request.
- R11: `op_sel`=7 is reserved. It sets `undef` and returns D unchanged.
- R12: Every accepted request with `feat_en` high and `op_sel` 0..6 clears `undef`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation select (see R3-R11) |
| imm2 | input | 2 | Word index into M for compression variants |
| feat_en | input | 1 | Feature enable; low makes the request undefined |
| d_in | input | 128 | State / destination operand D |
| n_in | input | 128 | Source operand N |
| m_in | input | 128 | Source operand M |
| a_in | input | 128 | Third source operand A (SS1 only) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| d_out | output | 128 | New value of D |
| undef | output | 1 | Request was undefined |

## Verification
The hardest case to reach is the word-3 lane of expansion part 1. That lane depends on word 0 as freshly computed in the same operation. A wrong chain shows up only when word 0's input terms are non-trivial and differ from the old D[0]. The stimulus therefore uses random full-width operands, and it also includes cases where D[0] is zero and N[0] and M[1] are not. A second hard point is the carry in the compression sums. Operands near 2^32 and requests sent back to back, with no idle gap, check both the modulo wrap and that the result register is refilled every cycle.

// File: rtl/sm3_assist_unit.sv
module sm3_assist_unit #(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [2:0]                op_sel,
  input  logic [1:0]                imm2,
  input  logic                      feat_en,
  input  logic [WORD_W*LANES-1:0]   d_in,
  input  logic [WORD_W*LANES-1:0]   n_in,
  input  logic [WORD_W*LANES-1:0]   m_in,
  input  logic [WORD_W*LANES-1:0]   a_in,
  output logic                      out_valid,
  output logic [WORD_W*LANES-1:0]   d_out,
  output logic                      undef
);
  localparam int VEC_W = WORD_W * LANES;
  localparam logic [2:0] OP_EXP1 = 3'd4;
  localparam logic [2:0] OP_EXP2 = 3'd5;
  localparam logic [2:0] OP_SS1  = 3'd6;
  localparam logic [2:0] OP_RSVD = 3'd7;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int unsigned s);
    logic [2*WORD_W-1:0] y;
    y = {x, x} >> s;
    return y[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] mix1(input logic [WORD_W-1:0] t);
    return t ^ rotr(t, 17) ^ rotr(t, 9);
  endfunction

  logic [WORD_W-1:0] dw [LANES];
  logic [WORD_W-1:0] nw [LANES];
  logic [WORD_W-1:0] mw [LANES];
  logic [WORD_W-1:0] e1 [LANES];
  logic [WORD_W-1:0] e2 [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign dw[g] = d_in[WORD_W*g +: WORD_W];
    assign nw[g] = n_in[WORD_W*g +: WORD_W];
    assign mw[g] = m_in[WORD_W*g +: WORD_W];
  end

  for (genvar g = 0; g < LANES - 1; g++) begin : g_exp1
    assign e1[g] = mix1(dw[g] ^ nw[g] ^ rotr(mw[g+1], 17));
  end
  assign e1[LANES-1] = mix1(dw[LANES-1] ^ nw[LANES-1] ^ rotr(e1[0], 17));

  logic [WORD_W-1:0] u2;
  assign u2 = nw[0] ^ rotr(mw[0], 25);
  for (genvar g = 0; g < LANES; g++) begin : g_exp2
    if (g == LANES - 1) begin : g_top
      assign e2[g] = dw[g] ^ nw[g] ^ rotr(mw[g], 25) ^ rotr(u2, 17) ^ rotr(u2, 2) ^ rotr(u2, 26);
    end else begin : g_low
      assign e2[g] = dw[g] ^ nw[g] ^ rotr(mw[g], 25);
    end
  end

  logic [WORD_W-1:0] ss1_w;
  assign ss1_w = rotr(rotr(nw[3], 20) + mw[3] + a_in[VEC_W-1 -: WORD_W], 25);

  logic [WORD_W-1:0] fsel, tsum, t_one, t_two_pre, t_two, w1_new;
  always_comb begin
    case (op_sel[1:0])
      2'd1:    fsel = (dw[3] & dw[2]) | (dw[3] & dw[1]) | (dw[2] & dw[1]);
      2'd3:    fsel = (dw[3] & dw[2]) | (~dw[3] & dw[1]);
      default: fsel = dw[3] ^ dw[2] ^ dw[1];
    endcase
  end
  assign tsum      = fsel + dw[0] + mw[imm2];
  assign t_one     = tsum + (nw[3] ^ rotr(dw[3], 20));
  assign t_two_pre = tsum + nw[3];
  assign t_two     = t_two_pre ^ rotr(t_two_pre, WORD_W - 9) ^ rotr(t_two_pre, WORD_W - 17);
  assign w1_new    = op_sel[1] ? rotr(dw[2], 13) : rotr(dw[2], 23);

  logic [VEC_W-1:0] result;
  logic             bad;
  assign bad = !feat_en || (op_sel == OP_RSVD);

  always_comb begin
    case (op_sel)
      OP_EXP1: result = {e1[3], e1[2], e1[1], e1[0]};
      OP_EXP2: result = {e2[3], e2[2], e2[1], e2[0]};
      OP_SS1:  result = {ss1_w, {(VEC_W - WORD_W){1'b0}}};
      default: result = {(op_sel[1] ? t_two : t_one), dw[3], w1_new, dw[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      d_out     <= '0;
      undef     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        d_out <= bad ? d_in : result;
        undef <= bad;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(d_out) && $stable(undef)); // R2
  AST_FEAT_OFF_UNDEF: assert property (@(posedge clk) disable iff (!rst_n) in_valid && !feat_en |=> undef && d_out == $past(d_in)); // R10
  AST_RSVD_UNDEF: assert property (@(posedge clk) disable iff (!rst_n) in_valid && op_sel == OP_RSVD |=> undef && d_out == $past(d_in)); // R11
  AST_SS1_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) in_valid && feat_en && op_sel == OP_SS1 |=> d_out[VEC_W-WORD_W-1:0] == '0); // R5
  AST_ROUND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) in_valid && feat_en && !op_sel[2] |=> d_out[WORD_W-1:0] == $past(d_in[2*WORD_W-1:WORD_W]) && d_out[3*WORD_W-1:2*WORD_W] == $past(d_in[4*WORD_W-1:3*WORD_W])); // R6
  AST_DEFINED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) in_valid && feat_en && op_sel != OP_RSVD |=> !undef); // R12
endmodule

// File: tb/tb_sm3_assist_unit.sv
module tb_sm3_assist_unit;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, feat_en = 1'b0;
  logic [2:0] op_sel = '0;
  logic [1:0] imm2 = '0;
  logic [127:0] d_in = '0, n_in = '0, m_in = '0, a_in = '0;
  logic out_valid, undef;
  logic [127:0] d_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [127:0] q_d[$];
  logic q_u[$];
  string q_tag[$];
  logic [127:0] last_d;
  logic last_u;
  bit have_last = 0;

  always #10 clk = ~clk;

  sm3_assist_unit dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .imm2(imm2),
    .feat_en(feat_en), .d_in(d_in), .n_in(n_in), .m_in(m_in), .a_in(a_in),
    .out_valid(out_valid), .d_out(d_out), .undef(undef));

  function automatic logic [31:0] rr(input logic [31:0] x, input int s);
    return (s == 0) ? x : ((x >> s) | (x << (32 - s)));
  endfunction
  function automatic logic [31:0] wd(input logic [127:0] v, input int i);
    return v[32*i +: 32];
  endfunction

  function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] ix,
      input logic [127:0] d, input logic [127:0] n, input logic [127:0] m, input logic [127:0] a);
    logic [31:0] r[4];
    logic [31:0] t, f, u;
    case (op)
      3'd4: begin
        for (int i = 0; i < 4; i++) begin
          t = wd(d, i) ^ wd(n, i) ^ rr((i < 3) ? wd(m, i + 1) : r[0], 17);
          r[i] = t ^ rr(t, 17) ^ rr(t, 9);
        end
      end
      3'd5: begin
        u = wd(n, 0) ^ rr(wd(m, 0), 25);
        for (int i = 0; i < 4; i++) r[i] = wd(d, i) ^ wd(n, i) ^ rr(wd(m, i), 25);
        r[3] = r[3] ^ rr(u, 17) ^ rr(u, 2) ^ rr(u, 26);
      end
      3'd6: begin
        r[0] = 0; r[1] = 0; r[2] = 0;
        r[3] = rr(rr(wd(n, 3), 20) + wd(m, 3) + wd(a, 3), 25);
      end
      default: begin
        if (op == 3'd1) f = (wd(d,3) & wd(d,2)) | (wd(d,3) & wd(d,1)) | (wd(d,2) & wd(d,1));
        else if (op == 3'd3) f = (wd(d,3) & wd(d,2)) | (~wd(d,3) & wd(d,1));
        else f = wd(d,3) ^ wd(d,2) ^ wd(d,1);
        t = f + wd(d, 0) + wd(m, int'(ix));
        if (op < 3'd2) begin
          t = t + (wd(n, 3) ^ rr(wd(d, 3), 20));
          r[1] = rr(wd(d, 2), 23);
        end else begin
          t = t + wd(n, 3);
          t = t ^ rr(t, 23) ^ rr(t, 15);
          r[1] = rr(wd(d, 2), 13);
        end
        r[0] = wd(d, 1); r[2] = wd(d, 3); r[3] = t;
      end
    endcase
    return {r[3], r[2], r[1], r[0]};
  endfunction

  task automatic check(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [1:0] ix, input logic fe,
      input logic [127:0] d, input logic [127:0] n, input logic [127:0] m, input logic [127:0] a, input string tag);
    @(negedge clk);
    op_sel = op; imm2 = ix; feat_en = fe; d_in = d; n_in = n; m_in = m; a_in = a; in_valid = 1'b1;
    if (!fe || op == 3'd7) begin q_d.push_back(d); q_u.push_back(1'b1); end
    else begin q_d.push_back(model(op, ix, d, n, m, a)); q_u.push_back(1'b0); end
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      d_in = {4{$urandom}};
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        if (q_d.size() == 0) check(1'b0, "R2 unexpected out_valid", 128'(out_valid), 128'd0);
        else begin
          logic [127:0] ed; logic eu; string tg;
          ed = q_d.pop_front(); eu = q_u.pop_front(); tg = q_tag.pop_front();
          check(d_out === ed, {tg, " d_out"}, d_out, ed);
          check(undef === eu, {tg, " undef"}, 128'(undef), 128'(eu));
          last_d = d_out; last_u = undef; have_last = 1;
        end
      end else if (rst_n && have_last) begin
        check(d_out === last_d && undef === last_u, "R2 hold while idle", d_out, last_d);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [127:0] d, n, m, a;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && undef === 1'b0 && d_out === '0, "R1 reset state", d_out, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && undef === 1'b0 && d_out === '0, "R1 after release", d_out, 128'd0);

    for (int k = 0; k < 6; k++) begin
      d = rnd128(); n = rnd128(); m = rnd128(); a = rnd128();
      drive(3'd4, 2'(k), 1'b1, d, n, m, a, "R3 expansion part 1");
      drive(3'd5, 2'(k), 1'b1, d, n, m, a, "R4 expansion part 2");
      drive(3'd6, 2'(k), 1'b1, d, n, m, a, "R5 SS1");
      idle(1);
    end
    drive(3'd4, 2'd0, 1'b1, {96'h0123456789abcdef01234567, 32'h0}, rnd128(), rnd128(), '0, "R3 word3 chain, D0 zero");
    drive(3'd6, 2'd0, 1'b1, rnd128(), {32'hffffffff, 96'h0}, {32'hffffffff, 96'h0}, {32'hffffffff, 96'h0}, "R5 carry wrap");
    idle(2);

    for (int op = 0; op < 4; op++) begin
      for (int ix = 0; ix < 4; ix++) begin
        d = rnd128(); n = rnd128(); m = rnd128();
        if (op < 2) drive(3'(op), 2'(ix), 1'b1, d, n, m, rnd128(), "R6 R7 R8 compression form 1");
        else        drive(3'(op), 2'(ix), 1'b1, d, n, m, rnd128(), "R6 R7 R9 compression form 2");
      end
      idle(1);
    end
    drive(3'd1, 2'd3, 1'b1, {4{32'hffffffff}}, {4{32'hffffffff}}, {4{32'hffffffff}}, '0, "R7 majority all ones wrap");
    drive(3'd3, 2'd2, 1'b1, {32'h00ff00ff, 32'h12345678, 32'h9abcdef0, 32'hfffffff0}, rnd128(), rnd128(), '0, "R7 choose mask");
    drive(3'd2, 2'd1, 1'b1, '0, '0, '0, '0, "R9 zero operands");
    idle(2);

    for (int op = 0; op < 8; op++) begin
      drive(3'(op), 2'd1, 1'b0, rnd128(), rnd128(), rnd128(), rnd128(), "R10 feature disabled");
    end
    idle(1);
    drive(3'd7, 2'd0, 1'b1, rnd128(), rnd128(), rnd128(), rnd128(), "R11 reserved op");
    drive(3'd5, 2'd0, 1'b1, rnd128(), rnd128(), rnd128(), rnd128(), "R12 undef clears after reserved");
    idle(3);

    done = 1;
    check(q_d.size() == 0, "R2 all results returned", 128'(q_d.size()), 128'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule